// File: doc/BRIEF.md
# 1-Wire Search Accelerator Datapath

This block speeds up the ROM search on a 1-Wire bus by resolving four ID bits per host byte. Before using it, the host sends the search command byte through the normal path and then sets the accelerator enable. After that, each byte the host writes carries four preferred branch directions. For each of the four bits, the block runs the bit exchange: a read slot for the true bit, a read slot for the complement, and a write slot that sends the chosen bit back to the bus. When all four bits are done, the block returns one byte that holds the four resolved ID bits and four discrepancy flags.

A full 64-bit search takes sixteen such exchanges, least significant nibble first. The host decides the next search path from the discrepancy flags. If the last resolved bit and its discrepancy flag are both set, the pass hit a bus error and must be retried. Bit-slot timing is not part of this block. Each slot is a request held until the timing engine answers with a one-cycle done pulse, and a read slot returns its sampled bit with that pulse.

Top module: `ow_search_accel`

## Requirements
- R1: Lane k takes its direction bit from written byte bit 2k+1. The even bit positions of the written byte have no effect on anything.
- R2: Lane 0 is handled first, and each lane takes exactly three slots in this order: true read, complement read, write. `slot_is_write` is 0 for a read slot and 1 for a write slot.
- R3: If the true and complement reads differ, the resolved bit equals the true read and the discrepancy flag is 0.
- R4: If both reads are 0, the discrepancy flag is 1 and the resolved bit equals that lane's host direction bit.
- R5: If both reads are 1, the resolved bit and the discrepancy flag are both 1. On lane 3 of the final nibble, this pair marks a bus error.
- R6: Each lane's write slot drives `slot_wbit` with that lane's resolved bit.
- R7: In the result byte, resolved bit k sits at bit 2k+1 and discrepancy flag k sits at bit 2k. The byte holds its value until the next exchange completes.
- R8: `tx_empty` goes low on the cycle after a write is accepted and stays low while slots are pending. When the last write slot completes, it returns high and `rx_full` is set in the same cycle that `rd_data` updates.
- R9: A `rd_strobe` clears `rx_full` on the next cycle.
- R10: While `accel_en` is low, written bytes are ignored and no slot is requested. Dropping `accel_en` during an exchange abandons it: `tx_empty` goes high and no result is posted.
- R11: A byte written while an exchange is in progress is ignored.
- R12: A slot request holds its kind and write bit unchanged until `slot_done` arrives.
- R13: After reset, no slot is requested, `tx_empty` is 1, `rx_full` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| accel_en | input | 1 | Accelerator mode enable, a command-register bit |
| wr_valid | input | 1 | One-cycle strobe: host writes a direction byte |
| wr_data | input | 2*LANES | Direction byte (odd positions used) |
| rd_strobe | input | 1 | One-cycle strobe: host reads the result byte |
| rd_data | output | 2*LANES | Interleaved resolved bits and discrepancy flags |
| tx_empty | output | 1 | No exchange in progress |
| rx_full | output | 1 | Result byte ready, sticky until read |
| slot_req | output | 1 | Slot request to the timing engine |
| slot_is_write | output | 1 | 0 = read slot, 1 = write slot |
| slot_wbit | output | 1 | Bit to send in a write slot |
| slot_done | input | 1 | One-cycle slot completion |
| slot_rbit | input | 1 | Sampled bus bit, valid with `slot_done` on a read slot |

## Verification
The assertions check the handshake rules on every cycle:
- the slot request holds steady until done;
- no slot is requested with the mode off;
- `tx_empty` is always the inverse of an outstanding request;
- `rx_full` only rises after a completed write slot and falls after a read strobe.

Only the bench scenarios can show that the resolved bits and flags are correct. They also cover the lane ordering, the interleaved bit positions, the write-slot values, and the ignored bytes (junk even bits, writes while busy, writes with the mode off, and a mid-exchange abort). These scenarios sweep every true/complement pattern across four lanes against arithmetic expectations.

// File: rtl/ow_search_pkg.sv
package ow_search_pkg;
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_RD_TRUE = 2'd1,
        PH_RD_CMPL = 2'd2,
        PH_WR_DIR  = 2'd3
    } phase_e;
endpackage

// File: rtl/ow_lane_codec.sv
// Interleave/deinterleave between host bytes and per-lane vectors.
module ow_lane_codec #(
    parameter int LANES = 4
) (
    input  logic [2*LANES-1:0] wr_byte,
    input  logic [LANES-1:0]   rom_bits,
    input  logic [LANES-1:0]   disc_bits,
    output logic [LANES-1:0]   dir_bits,
    output logic [2*LANES-1:0] rd_byte
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign dir_bits[k]      = wr_byte[2*k+1];
        assign rd_byte[2*k+1]   = rom_bits[k];
        assign rd_byte[2*k]     = disc_bits[k];
    end
endmodule

// File: rtl/ow_bit_resolver.sv
// Chooses the branch bit from the true/complement reads and host direction.
module ow_bit_resolver (
    input  logic true_bit,
    input  logic cmpl_bit,
    input  logic dir_bit,
    output logic res_bit,
    output logic res_flag
);
    always_comb begin
        if (true_bit != cmpl_bit) begin
            res_bit  = true_bit;
            res_flag = 1'b0;
        end else if (!true_bit) begin
            res_bit  = dir_bit;
            res_flag = 1'b1;
        end else begin
            res_bit  = 1'b1;
            res_flag = 1'b1;
        end
    end
endmodule

// File: rtl/ow_slot_sequencer.sv
// Walks the lanes through read/read/write slots and keeps the host flags.
module ow_slot_sequencer
    import ow_search_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accel_en,
    input  logic             wr_valid,
    input  logic [LANES-1:0] dir_in,
    input  logic             rd_strobe,
    input  logic             slot_done,
    input  logic             slot_rbit,
    input  logic             res_bit,
    input  logic             res_flag,
    output logic             slot_req,
    output logic             slot_is_write,
    output logic             slot_wbit,
    output logic             cur_true,
    output logic             cur_dir,
    output logic [LANES-1:0] out_rom,
    output logic [LANES-1:0] out_disc,
    output logic             tx_empty,
    output logic             rx_full
);
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);

    typedef struct packed {
        phase_e           phase;
        logic [IDX_W-1:0] idx;
        logic             tbit;
        logic [LANES-1:0] dir;
        logic [LANES-1:0] rom;
        logic [LANES-1:0] disc;
        logic [LANES-1:0] snap_rom;
        logic [LANES-1:0] snap_disc;
        logic             txe;
        logic             rxf;
    } seq_state_t;

    seq_state_t s_d, s_q;
    logic finishing;

    always_comb begin
        s_d       = s_q;
        finishing = 1'b0;

        if (rd_strobe) begin
            s_d.rxf = 1'b0;
        end

        unique case (s_q.phase)
            PH_IDLE: begin
                if (accel_en && wr_valid) begin
                    s_d.dir   = dir_in;
                    s_d.idx   = '0;
                    s_d.rom   = '0;
                    s_d.disc  = '0;
                    s_d.txe   = 1'b0;
                    s_d.phase = PH_RD_TRUE;
                end
            end
            PH_RD_TRUE: begin
                if (slot_done) begin
                    s_d.tbit  = slot_rbit;
                    s_d.phase = PH_RD_CMPL;
                end
            end
            PH_RD_CMPL: begin
                if (slot_done) begin
                    s_d.rom[s_q.idx]  = res_bit;
                    s_d.disc[s_q.idx] = res_flag;
                    s_d.phase         = PH_WR_DIR;
                end
            end
            PH_WR_DIR: begin
                if (slot_done) begin
                    if (s_q.idx == LAST_IDX) begin
                        finishing     = 1'b1;
                        s_d.snap_rom  = s_q.rom;
                        s_d.snap_disc = s_q.disc;
                        s_d.rxf       = 1'b1;
                        s_d.txe       = 1'b1;
                        s_d.phase     = PH_IDLE;
                    end else begin
                        s_d.idx   = s_q.idx + 1'b1;
                        s_d.phase = PH_RD_TRUE;
                    end
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase

        if (!accel_en) begin
            s_d.phase = PH_IDLE;
            s_d.txe   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
            s_q.txe   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign slot_req      = (s_q.phase != PH_IDLE);
    assign slot_is_write = (s_q.phase == PH_WR_DIR);
    assign slot_wbit     = s_q.rom[s_q.idx];
    assign cur_true      = s_q.tbit;
    assign cur_dir       = s_q.dir[s_q.idx];
    assign out_rom       = s_q.snap_rom;
    assign out_disc      = s_q.snap_disc;
    assign tx_empty      = s_q.txe;
    assign rx_full       = s_q.rxf;

    // R12: an unanswered request keeps its kind and write bit
    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req && !slot_done && accel_en) |=>
            (slot_req && $stable(slot_is_write) && $stable(slot_wbit)));

    // R10: no slot activity once the mode is off
    assert_off_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !accel_en |=> !slot_req);

    // R8: tx_empty mirrors the absence of outstanding slots
    assert_busy_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slot_req != tx_empty);

    // R8: result flag only rises after a completed write slot
    assert_rx_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(slot_is_write && slot_done));

    // R9: a read strobe clears the flag unless a new result lands
    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !finishing) |=> !rx_full);
endmodule

// File: rtl/ow_search_accel.sv
module ow_search_accel #(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accel_en,
    input  logic               wr_valid,
    input  logic [2*LANES-1:0] wr_data,
    input  logic               rd_strobe,
    output logic [2*LANES-1:0] rd_data,
    output logic               tx_empty,
    output logic               rx_full,
    output logic               slot_req,
    output logic               slot_is_write,
    output logic               slot_wbit,
    input  logic               slot_done,
    input  logic               slot_rbit
);
    logic [LANES-1:0] dir_bits;
    logic [LANES-1:0] snap_rom;
    logic [LANES-1:0] snap_disc;
    logic             cur_true;
    logic             cur_dir;
    logic             res_bit;
    logic             res_flag;

    ow_lane_codec #(.LANES(LANES)) u_codec (
        .wr_byte   (wr_data),
        .rom_bits  (snap_rom),
        .disc_bits (snap_disc),
        .dir_bits  (dir_bits),
        .rd_byte   (rd_data)
    );

    ow_bit_resolver u_resolve (
        .true_bit (cur_true),
        .cmpl_bit (slot_rbit),
        .dir_bit  (cur_dir),
        .res_bit  (res_bit),
        .res_flag (res_flag)
    );

    ow_slot_sequencer #(.LANES(LANES)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .accel_en      (accel_en),
        .wr_valid      (wr_valid),
        .dir_in        (dir_bits),
        .rd_strobe     (rd_strobe),
        .slot_done     (slot_done),
        .slot_rbit     (slot_rbit),
        .res_bit       (res_bit),
        .res_flag      (res_flag),
        .slot_req      (slot_req),
        .slot_is_write (slot_is_write),
        .slot_wbit     (slot_wbit),
        .cur_true      (cur_true),
        .cur_dir       (cur_dir),
        .out_rom       (snap_rom),
        .out_disc      (snap_disc),
        .tx_empty      (tx_empty),
        .rx_full       (rx_full)
    );
endmodule

// File: tb/tb_ow_search_accel.sv
module tb_ow_search_accel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       accel_en = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rd_data;
    logic       tx_empty, rx_full, slot_req, slot_is_write, slot_wbit;
    logic       slot_done = 1'b0;
    logic       slot_rbit = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ow_search_accel #(.LANES(4)) dut (
        .clk(clk), .rst_n(rst_n), .accel_en(accel_en), .wr_valid(wr_valid),
        .wr_data(wr_data), .rd_strobe(rd_strobe), .rd_data(rd_data),
        .tx_empty(tx_empty), .rx_full(rx_full), .slot_req(slot_req),
        .slot_is_write(slot_is_write), .slot_wbit(slot_wbit),
        .slot_done(slot_done), .slot_rbit(slot_rbit)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_req();
        int n = 0;
        while (!slot_req && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk(slot_req == 1'b1, "R2 slot request missing", int'(slot_req), 1);
    endtask

    // bc: bit 2k = true read of lane k, bit 2k+1 = complement read
    task automatic exchange(input logic [3:0] dir, input logic [7:0] bc,
                            input logic [3:0] junk, input int stall,
                            input bit inject);
        logic [7:0] wbyte;
        logic [7:0] exp_byte;
        logic [3:0] r, d;
        for (int k = 0; k < 4; k++) begin
            logic b, c;
            b = bc[2*k];
            c = bc[2*k+1];
            if (b != c) begin r[k] = b; d[k] = 1'b0; end
            else if (!b) begin r[k] = dir[k]; d[k] = 1'b1; end
            else begin r[k] = 1'b1; d[k] = 1'b1; end
            wbyte[2*k+1] = dir[k];
            wbyte[2*k]   = junk[k];
            exp_byte[2*k+1] = r[k];
            exp_byte[2*k]   = d[k];
        end
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = wbyte;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        chk(tx_empty == 1'b0, "R8 tx_empty low while busy", int'(tx_empty), 0);
        for (int k = 0; k < 4; k++) begin
            for (int s = 0; s < 3; s++) begin
                logic kind0;
                wait_req();
                chk(slot_is_write == (s == 2), "R2 slot kind order", int'(slot_is_write), int'(s == 2));
                if (s == 2) begin
                    string tag;
                    tag = (bc[2*k] != bc[2*k+1]) ? "R6 R3" : (!bc[2*k] ? "R6 R4" : "R6 R5");
                    chk(slot_wbit == r[k], tag, int'(slot_wbit), int'(r[k]));
                end
                kind0 = slot_is_write;
                for (int w = 0; w < stall; w++) begin
                    @(negedge clk);
                    chk(slot_req && slot_is_write == kind0, "R12 request held", int'(slot_is_write), int'(kind0));
                end
                slot_rbit = (s == 0) ? bc[2*k] : ((s == 1) ? bc[2*k+1] : 1'b0);
                slot_done = 1'b1;
                @(posedge clk);
                @(negedge clk);
                slot_done = 1'b0;
                if (inject && k == 0 && s == 0) begin
                    wr_valid = 1'b1;
                    wr_data  = ~wbyte;
                    @(posedge clk);
                    @(negedge clk);
                    wr_valid = 1'b0;
                end
            end
        end
        chk(rx_full == 1'b1, "R8 rx_full after last slot", int'(rx_full), 1);
        chk(tx_empty == 1'b1 && slot_req == 1'b0, "R8 idle after exchange", int'(slot_req), 0);
        chk(rd_data == exp_byte, inject ? "R11 R7 result" : "R7 R1 result", int'(rd_data), int'(exp_byte));
        if (bc[6] && bc[7])
            chk(rd_data[7] && rd_data[6], "R5 bus error marker", int'(rd_data[7:6]), 3);
        rd_strobe = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_strobe = 1'b0;
        chk(rx_full == 1'b0, "R9 read clears rx_full", int'(rx_full), 0);
        chk(rd_data == exp_byte, "R7 result held", int'(rd_data), int'(exp_byte));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk(slot_req == 1'b0, "R13 no request", int'(slot_req), 0);
        chk(tx_empty == 1'b1, "R13 tx_empty", int'(tx_empty), 1);
        chk(rx_full == 1'b0, "R13 rx_full", int'(rx_full), 0);
        chk(rd_data == 8'h00, "R13 rd_data", int'(rd_data), 0);

        // R10: writes with mode off are ignored
        wr_valid = 1'b1;
        wr_data  = 8'hAA;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(slot_req == 1'b0, "R10 no slot while off", int'(slot_req), 0);
        chk(tx_empty == 1'b1 && rx_full == 1'b0, "R10 flags unchanged while off", int'(tx_empty), 1);

        accel_en = 1'b1;
        @(negedge clk);

        // Sweep all true/complement patterns
        for (int i = 0; i < 256; i++)
            exchange(4'((i * 5 + 3) & 15), 8'(i), 4'(i ^ 10), i % 3, 1'b0);

        // R4: every direction with all-zero reads
        for (int j = 0; j < 16; j++)
            exchange(4'(j), 8'h00, 4'(~j), 0, 1'b0);

        // R11: write during an exchange is ignored
        exchange(4'b1010, 8'b0000_1001, 4'b0101, 1, 1'b1);

        // R10: abort mid-exchange
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = 8'hFF;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        for (int s = 0; s < 2; s++) begin
            wait_req();
            slot_rbit = 1'b1;
            slot_done = 1'b1;
            @(posedge clk);
            @(negedge clk);
            slot_done = 1'b0;
        end
        accel_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(slot_req == 1'b0, "R10 abort drops request", int'(slot_req), 0);
        chk(tx_empty == 1'b1, "R10 abort tx_empty", int'(tx_empty), 1);
        chk(rx_full == 1'b0, "R10 abort posts no result", int'(rx_full), 0);
        accel_en = 1'b1;
        exchange(4'b0110, 8'b1100_0110, 4'b0000, 0, 1'b0);

        finish_run();
    end
endmodule